// File: doc/BRIEF.md
# Clock Operating-Level Step Sequencer

This block moves a processor clock domain from its present operating level to a requested one. Levels are numbered 0 to 15; a smaller number is a faster clock. A request enters through a valid/ready pair. The block then updates a set of register-style outputs in a fixed order: a core clock mux select, a PLL lock-time count, a PLL configuration word and two packed divider words. After each update it waits on the matching status input before it takes the next step. When the sequence ends, a one-cycle `done` pulse marks the new level as current. A one-cycle `err` pulse marks a refused or abandoned request.

Back-pressure works as follows. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A requester that holds `req_valid` during a sequence simply waits. The PLL word places M at bits [25:16], P at bits [13:8] and S at bits [2:0]. Levels 0 to 3 are not supported and have an all-zero PLL word. Levels 4 to 15 use these (M,P,S) values:

| Level | M,P,S | Level | M,P,S | Level | M,P,S |
|---|---|---|---|---|---|
| 4 | 325,6,0 | 8 | 150,4,0 | 12 | 125,3,1 |
| 5 | 200,4,0 | 9 | 100,3,0 | 13 | 100,3,1 |
| 6 | 275,6,0 | 10 | 175,3,1 | 14 | 200,4,2 |
| 7 | 125,3,0 | 11 | 200,4,1 | 15 | 100,3,2 |

The first divider word holds eight 3-bit fields, one at each nibble boundary:

| Bits | Value |
|---|---|
| [6:4] (core) | 3 for levels up to 5, 2 for levels 6 to 9, 1 otherwise |
| [26:24] (PLL side) | 3 for levels up to 5, 2 for levels 6 to 8, 1 otherwise |
| [18:16] (trace) | 6 for level 4, 1 for level 15, (16-L)/2 otherwise |
| [11:8] | 7 |
| [15:12] | 7 |
| [22:20] | 1 |
| All other fields | 0 |

The second divider word has bits [6:4] = 2 and bits [2:0] = 1 for levels up to 8, 0 otherwise.

Top module: `freq_step_seq`

## Requirements
- R1: After reset the current level is SAFE_LEVEL (default 9), `mux_sel` is 0 (main PLL), the PLL and divider words hold that level's values, `req_ready` is 1, and `busy`, `done` and `err` are 0.
- R2: `req_ready` is 1 only when idle, and a request is taken only on an edge with `req_valid` and `req_ready` both high. From the cycle after acceptance, `busy` is 1 and `req_ready` is 0 until the cycle after the `done` or `err` pulse. No output changes while idle.
- R3: A request for the current level produces a `done` pulse and changes no output.
- R4: A request for a level with an all-zero PLL word (levels 0 to 3) produces an `err` pulse, changes no output and leaves the current level unchanged.
- R5: After a successful change, `pll_cfg` equals the target level's word in the M/P/S packing and table above.
- R6: After a successful change, `div0_word` and `div1_word` equal the target level's values from the field definitions above.
- R7: If the live M and P fields already match the target and `mux_sel` is 0, only `pll_cfg[2:0]` is rewritten. `mux_sel` stays 0 and `lock_time` is not touched.
- R8: Otherwise the PLL relock runs in this order:
  1. `mux_sel` is set to 1.
  2. The block waits until `mux_status[18:16]` equals 2.
  3. `lock_time` is set to P*250.
  4. The full PLL word is written.
  5. The block waits until `pll_status[29]` is 1.
  6. `mux_sel` is set to 0.
  7. The block waits until `mux_status[18:16]` equals 1.
  M/P changes happen only while `mux_sel` is 1, and `mux_sel` is 0 at `done`.
- R9: For a faster target (lower index), the dividers are updated before the PLL. For a slower target, the PLL is updated before the dividers.
- R10: The divider step writes `div0_word` and waits until `div0_status & 32'h11111111` is zero. Only then does it write `div1_word`, and it then waits until `div1_status & 8'h11` is zero.
- R11: If any wait lasts longer than `timeout_limit` cycles, `err` pulses, the block returns to idle and the current level is unchanged.
- R12: `done` lasts exactly one cycle, and `cur_level` shows the target from the cycle after `done`. `cur_level` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_level | input | 4 | Target level |
| timeout_limit | input | 16 | Maximum cycles allowed in any wait |
| mux_status | input | 32 | Mux state, field at [18:16] |
| pll_status | input | 32 | PLL state, lock flag at bit 29 |
| div0_status | input | 32 | First divider word busy bits |
| div1_status | input | 8 | Second divider word busy bits |
| mux_sel | output | 1 | Core mux: 0 main PLL, 1 alternate PLL |
| lock_time | output | 16 | PLL lock-time count |
| pll_cfg | output | 32 | PLL M/P/S word |
| div0_word | output | 32 | First divider word |
| div1_word | output | 8 | Second divider word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal or timeout pulse |
| cur_level | output | 4 | Current level |

## Verification
Some rules are checked by assertions on every cycle:
- M/P fields change only under the alternate mux.
- `lock_time` already matches the new P when M/P change.
- The mux is home at `done`.
- The current level moves only after `done`.
- No output moves while idle.
- The second divider word is written only after the first word's busy bits read clear.

Other behaviour can be shown only by the bench's scenarios:
- The order of divider and PLL updates for rising and falling targets.
- The choice between an S-only rewrite and a full relock.
- The final table values.
- Refusal of unsupported levels.
- Recovery after a timeout.

The bench sweeps every pair of supported levels to cover these.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int LVL_W    = 4;
  localparam int NUM_LVL  = 1 << LVL_W;
  localparam int M_LSB    = 16;
  localparam int P_LSB    = 8;
  localparam int MUXF_LSB = 16;
  localparam int LOCK_BIT = 29;
  localparam int DIV0_FIELDS = 8;
  localparam int DIV1_FIELDS = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PLAN, ST_DIV0, ST_DIV0_WT, ST_DIV1, ST_DIV1_WT, ST_SONLY,
    ST_MUX_ALT, ST_ALT_WT, ST_LOCKT, ST_PMS, ST_LOCK_WT, ST_MUX_MAIN,
    ST_MAIN_WT, ST_DONE, ST_FAIL
  } fsm_t;

  // one busy bit per 4-bit field, at the field's lowest bit
  function automatic logic [31:0] busy_mask(input int nfields);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < nfields; i++) m[4*i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fcs_level_rom.sv
module fcs_level_rom
  import fcs_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  output logic [31:0]      pll_word,
  output logic [31:0]      div0_word,
  output logic [7:0]       div1_word
);
  logic [9:0] m;
  logic [5:0] p;
  logic [2:0] s;
  logic [2:0] f_core, f_pside, f_trace, f_copy;
  logic [4:0] span;

  always_comb begin
    unique case (lvl)
      4'd4:    begin m = 10'd325; p = 6'd6; s = 3'd0; end
      4'd5:    begin m = 10'd200; p = 6'd4; s = 3'd0; end
      4'd6:    begin m = 10'd275; p = 6'd6; s = 3'd0; end
      4'd7:    begin m = 10'd125; p = 6'd3; s = 3'd0; end
      4'd8:    begin m = 10'd150; p = 6'd4; s = 3'd0; end
      4'd9:    begin m = 10'd100; p = 6'd3; s = 3'd0; end
      4'd10:   begin m = 10'd175; p = 6'd3; s = 3'd1; end
      4'd11:   begin m = 10'd200; p = 6'd4; s = 3'd1; end
      4'd12:   begin m = 10'd125; p = 6'd3; s = 3'd1; end
      4'd13:   begin m = 10'd100; p = 6'd3; s = 3'd1; end
      4'd14:   begin m = 10'd200; p = 6'd4; s = 3'd2; end
      4'd15:   begin m = 10'd100; p = 6'd3; s = 3'd2; end
      default: begin m = '0;      p = '0;   s = '0;   end
    endcase
    span    = 5'd16 - {1'b0, lvl};
    f_core  = (lvl <= 4'd5) ? 3'd3 : (lvl <= 4'd9) ? 3'd2 : 3'd1;
    f_pside = (lvl <= 4'd5) ? 3'd3 : (lvl <= 4'd8) ? 3'd2 : 3'd1;
    f_trace = (lvl <= 4'd4) ? 3'd6 : (lvl == 4'd15) ? 3'd1 : span[3:1];
    f_copy  = (lvl <= 4'd8) ? 3'd1 : 3'd0;
  end

  assign pll_word  = {6'b0, m, 2'b0, p, 5'b0, s};
  assign div0_word = {4'h0, 1'b0, f_pside, 4'h1, 1'b0, f_trace,
                      4'h7, 4'h7, 1'b0, f_core, 4'h0};
  assign div1_word = {4'h2, 1'b0, f_copy};
endmodule

// File: rtl/fcs_wait_timer.sv
module fcs_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/freq_step_seq.sv
module freq_step_seq
  import fcs_pkg::*;
#(
  parameter int SAFE_LEVEL = 9,
  parameter int TMO_W      = 16,
  parameter int LOCK_W     = 16,
  parameter int LOCK_UNIT  = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LVL_W-1:0] req_level,
  input  logic [TMO_W-1:0] timeout_limit,
  input  logic [31:0]      mux_status,
  input  logic [31:0]      pll_status,
  input  logic [31:0]      div0_status,
  input  logic [7:0]       div1_status,
  output logic             mux_sel,
  output logic [LOCK_W-1:0] lock_time,
  output logic [31:0]      pll_cfg,
  output logic [31:0]      div0_word,
  output logic [7:0]       div1_word,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [LVL_W-1:0] cur_level
);
  localparam logic [31:0] DIV0_MASK = busy_mask(DIV0_FIELDS);
  localparam logic [7:0]  DIV1_MASK = 8'(busy_mask(DIV1_FIELDS));
  localparam logic [LVL_W-1:0] SAFE = LVL_W'(SAFE_LEVEL);

  fsm_t             state;
  logic [LVL_W-1:0] tgt_q;
  logic             div_left, pll_left;

  // ROM lookups: target level and reset level
  logic [31:0] t_pll, t_div0, s_pll, s_div0;
  logic [7:0]  t_div1, s_div1;

  fcs_level_rom u_rom_tgt (
    .lvl(tgt_q), .pll_word(t_pll), .div0_word(t_div0), .div1_word(t_div1));
  fcs_level_rom u_rom_safe (
    .lvl(SAFE), .pll_word(s_pll), .div0_word(s_div0), .div1_word(s_div1));

  // shared timeout for every wait state
  logic in_wait, tmo;
  assign in_wait = (state == ST_DIV0_WT) || (state == ST_DIV1_WT) ||
                   (state == ST_ALT_WT)  || (state == ST_LOCK_WT) ||
                   (state == ST_MAIN_WT);

  fcs_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_wait), .limit(timeout_limit),
    .expired(tmo));

  // decisions derived from the live PLL word and the target entry
  logic       mp_match, faster;
  logic [2:0] mux_field;
  fsm_t       pll_entry, after_pll, after_div;

  assign mp_match  = (pll_cfg[25:P_LSB] == t_pll[25:P_LSB]) && !mux_sel;
  assign faster    = tgt_q < cur_level;
  assign mux_field = mux_status[MUXF_LSB +: 3];
  assign pll_entry = mp_match ? ST_SONLY : ST_MUX_ALT;
  assign after_pll = div_left ? ST_DIV0 : ST_DONE;
  assign after_div = pll_left ? pll_entry : ST_DONE;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign err       = (state == ST_FAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tgt_q     <= SAFE;
      cur_level <= SAFE;
      div_left  <= 1'b0;
      pll_left  <= 1'b0;
      mux_sel   <= 1'b0;
      lock_time <= '0;
      pll_cfg   <= s_pll;
      div0_word <= s_div0;
      div1_word <= s_div1;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          tgt_q <= req_level;
          state <= ST_PLAN;
        end
        ST_PLAN: begin
          if (tgt_q == cur_level) state <= ST_DONE;
          else if (t_pll == '0)   state <= ST_FAIL;
          else begin
            div_left <= 1'b1;
            pll_left <= 1'b1;
            state    <= faster ? ST_DIV0 : pll_entry;
          end
        end
        ST_DIV0: begin
          div0_word <= t_div0;
          state     <= ST_DIV0_WT;
        end
        ST_DIV0_WT: begin
          if (tmo) state <= ST_FAIL;
          else if ((div0_status & DIV0_MASK) == '0) state <= ST_DIV1;
        end
        ST_DIV1: begin
          div1_word <= t_div1;
          state     <= ST_DIV1_WT;
        end
        ST_DIV1_WT: begin
          if (tmo) state <= ST_FAIL;
          else if ((div1_status & DIV1_MASK) == '0) begin
            div_left <= 1'b0;
            state    <= after_div;
          end
        end
        ST_SONLY: begin
          pll_cfg[2:0] <= t_pll[2:0];
          pll_left     <= 1'b0;
          state        <= after_pll;
        end
        ST_MUX_ALT: begin
          mux_sel <= 1'b1;
          state   <= ST_ALT_WT;
        end
        ST_ALT_WT: begin
          if (tmo) state <= ST_FAIL;
          else if (mux_field == 3'd2) state <= ST_LOCKT;
        end
        ST_LOCKT: begin
          lock_time <= LOCK_W'(32'(t_pll[P_LSB +: 6]) * LOCK_UNIT);
          state     <= ST_PMS;
        end
        ST_PMS: begin
          pll_cfg <= t_pll;
          state   <= ST_LOCK_WT;
        end
        ST_LOCK_WT: begin
          if (tmo) state <= ST_FAIL;
          else if (pll_status[LOCK_BIT]) state <= ST_MUX_MAIN;
        end
        ST_MUX_MAIN: begin
          mux_sel <= 1'b0;
          state   <= ST_MAIN_WT;
        end
        ST_MAIN_WT: begin
          if (tmo) state <= ST_FAIL;
          else if (mux_field == 3'd1) begin
            pll_left <= 1'b0;
            state    <= after_pll;
          end
        end
        ST_DONE: begin
          cur_level <= tgt_q;
          state     <= ST_IDLE;
        end
        ST_FAIL: begin
          div_left <= 1'b0;
          pll_left <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_MP_UNDER_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_cfg[25:P_LSB]) |-> mux_sel); // R8
  AST_LOCKT_BEFORE_MP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_cfg[25:P_LSB]) |-> (32'(lock_time) == 32'(pll_cfg[13:8]) * LOCK_UNIT)); // R8
  AST_MUX_HOME_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mux_sel); // R8
  AST_LEVEL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_level) |-> $past(done)); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(pll_cfg) && $stable(div0_word) && $stable(div1_word) && $stable(mux_sel))); // R2
  AST_DIV1_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div1_word) |-> ($past(div0_status, 2) & DIV0_MASK) == '0); // R10
endmodule

// File: tb/freq_step_seq_bench.sv
`timescale 1ns/1ps
module freq_step_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_level = '0;
  logic [15:0] timeout_limit = 16'd100;
  logic [31:0] mux_status, pll_status, div0_status;
  logic [7:0]  div1_status;
  logic        mux_sel, busy, done, err;
  logic [15:0] lock_time;
  logic [31:0] pll_cfg, div0_word;
  logic [7:0]  div1_word;
  logic [3:0]  cur_level;

  freq_step_seq u_freq_step_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_level(req_level), .timeout_limit(timeout_limit),
    .mux_status(mux_status), .pll_status(pll_status),
    .div0_status(div0_status), .div1_status(div1_status),
    .mux_sel(mux_sel), .lock_time(lock_time), .pll_cfg(pll_cfg),
    .div0_word(div0_word), .div1_word(div1_word), .busy(busy),
    .done(done), .err(err), .cur_level(cur_level));

  int n_cmp = 0, n_bad = 0;
  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // expected per-level values from the requirements
  function automatic logic [31:0] exp_pll(input int l);
    int m, p, s;
    case (l)
      4: begin m = 325; p = 6; s = 0; end   5: begin m = 200; p = 4; s = 0; end
      6: begin m = 275; p = 6; s = 0; end   7: begin m = 125; p = 3; s = 0; end
      8: begin m = 150; p = 4; s = 0; end   9: begin m = 100; p = 3; s = 0; end
      10: begin m = 175; p = 3; s = 1; end  11: begin m = 200; p = 4; s = 1; end
      12: begin m = 125; p = 3; s = 1; end  13: begin m = 100; p = 3; s = 1; end
      14: begin m = 200; p = 4; s = 2; end  15: begin m = 100; p = 3; s = 2; end
      default: begin m = 0; p = 0; s = 0; end
    endcase
    return 32'(m * 65536 + p * 256 + s);
  endfunction
  function automatic logic [31:0] exp_div0(input int l);
    int core, pside, trace;
    core  = (l <= 5) ? 3 : (l <= 9) ? 2 : 1;
    pside = (l <= 5) ? 3 : (l <= 8) ? 2 : 1;
    trace = (l <= 4) ? 6 : (l == 15) ? 1 : (16 - l) / 2;
    return 32'(core * 16 + 7 * 256 + 7 * 4096 + trace * 65536 + 1048576 + pside * 16777216);
  endfunction
  function automatic logic [7:0] exp_div1(input int l);
    return 8'(32 + ((l <= 8) ? 1 : 0));
  endfunction

  // responders and event stamps
  logic [2:0] mux_field = 3'd1;
  logic       lock_bit = 1'b1, d0_busy = 1'b0, d1_busy = 1'b0, stall_div0 = 1'b0;
  int mux_cnt = 0, lock_cnt = 0, d0_cnt = 0, d1_cnt = 0, cyc = 1;
  int t_mux = 0, t_pll = 0, t_div0 = 0, t_div1 = 0;
  logic        p_mux = 1'b0;
  logic [31:0] p_pll = '0, p_div0 = '0;
  logic [7:0]  p_div1 = '0;

  assign mux_status  = {13'b0, mux_field, 16'b0};
  assign pll_status  = {2'b0, lock_bit, 29'b0};
  assign div0_status = d0_busy ? 32'h1111_1111 : 32'h0;
  assign div1_status = d1_busy ? 8'h11 : 8'h0;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (mux_sel != p_mux) begin
          mux_cnt = 3; mux_field = 3'd0;
          if (mux_sel && t_mux == 0) t_mux = cyc;
        end else if (mux_cnt > 0) begin
          mux_cnt--;
          if (mux_cnt == 0) mux_field = mux_sel ? 3'd2 : 3'd1;
        end
        if (pll_cfg[25:8] != p_pll[25:8]) begin lock_bit = 1'b0; lock_cnt = 5; end
        else if (lock_cnt > 0) begin lock_cnt--; if (lock_cnt == 0) lock_bit = 1'b1; end
        if (pll_cfg != p_pll && t_pll == 0) t_pll = cyc;
        if (div0_word != p_div0) begin
          d0_cnt = 4; d0_busy = 1'b1;
          if (t_div0 == 0) t_div0 = cyc;
        end else begin
          if (d0_cnt > 0) d0_cnt--;
          if (d0_cnt == 0) d0_busy = stall_div0;
        end
        if (div1_word != p_div1) begin
          d1_cnt = 2; d1_busy = 1'b1;
          if (t_div1 == 0) t_div1 = cyc;
        end else begin
          if (d1_cnt > 0) d1_cnt--;
          if (d1_cnt == 0) d1_busy = 1'b0;
        end
      end
      p_mux = mux_sel; p_pll = pll_cfg; p_div0 = div0_word; p_div1 = div1_word;
    end
  end

  int model_cur = 9;

  task automatic run_xact(input int tgt, input bit exp_tmo);
    logic [31:0] o_pll, o_div0;
    logic [7:0]  o_div1;
    logic [15:0] o_lock;
    bit got_done, got_err, full;
    int old, guard;
    old = model_cur;
    @(negedge clk);
    o_pll = pll_cfg; o_div0 = div0_word; o_div1 = div1_word; o_lock = lock_time;
    t_mux = 0; t_pll = 0; t_div0 = 0; t_div1 = 0;
    full = (o_pll[25:8] != exp_pll(tgt) >> 8);
    req_valid = 1'b1; req_level = 4'(tgt);
    guard = 0;
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R2", "busy/ready after accept", {busy, req_ready}, 2'b10);
    got_done = 0; got_err = 0; guard = 0;
    while (guard < 2000) begin
      if (done) got_done = 1;
      if (err) got_err = 1;
      if (got_done || got_err) break;
      @(negedge clk); guard++;
    end
    @(negedge clk);
    check(!done && !err && !busy && req_ready, "R12", "pulse one cycle",
          {done, err, busy, req_ready}, 4'b0001);
    if (exp_tmo) begin
      check(got_err && !got_done, "R11", "timeout err", {got_err, got_done}, 2'b10);
      check(cur_level == 4'(old), "R11", "level kept", cur_level, old);
    end else if (exp_pll(tgt) == 0) begin
      check(got_err && !got_done, "R4", "unsupported err", {got_err, got_done}, 2'b10);
      check(cur_level == 4'(old), "R4", "level kept", cur_level, old);
      check(pll_cfg == o_pll && div0_word == o_div0 && div1_word == o_div1,
            "R4", "words unchanged", pll_cfg, o_pll);
    end else if (tgt == old) begin
      check(got_done && !got_err, "R3", "same-level done", {got_done, got_err}, 2'b10);
      check(pll_cfg == o_pll && div0_word == o_div0 && div1_word == o_div1 &&
            lock_time == o_lock && !mux_sel, "R3", "nothing changed", pll_cfg, o_pll);
    end else begin
      check(got_done && !got_err, "R12", "done", {got_done, got_err}, 2'b10);
      check(cur_level == 4'(tgt), "R12", "cur_level", cur_level, tgt);
      check(pll_cfg == exp_pll(tgt), "R5", "pll_cfg", pll_cfg, exp_pll(tgt));
      check(div0_word == exp_div0(tgt), "R6", "div0_word", div0_word, exp_div0(tgt));
      check(div1_word == exp_div1(tgt), "R6", "div1_word", div1_word, exp_div1(tgt));
      check(!mux_sel, "R8", "mux home", mux_sel, 0);
      if (full) begin
        check(32'(lock_time) == 32'((exp_pll(tgt) >> 8) & 63) * 250, "R8", "lock_time",
              lock_time, ((exp_pll(tgt) >> 8) & 63) * 250);
        check(t_mux != 0 && t_pll - t_mux >= 5, "R8", "mux switch then status wait before word",
              t_pll - t_mux, 5);
      end else begin
        check(t_mux == 0 && lock_time == o_lock, "R7", "S-only no mux/lock", t_mux, 0);
      end
      if (t_div0 != 0 && t_pll != 0) begin
        if (tgt < old) check(t_div0 < t_pll, "R9", "faster: dividers first", t_div0, t_pll);
        else           check(t_pll < t_div0, "R9", "slower: PLL first", t_pll, t_div0);
      end
      if (t_div0 != 0 && t_div1 != 0)
        check(t_div1 - t_div0 >= 6, "R10", "div1 after div0 busy clear", t_div1 - t_div0, 6);
      model_cur = tgt;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cur_level == 4'd9, "R1", "reset level", cur_level, 9);
    check(!mux_sel && pll_cfg == exp_pll(9), "R1", "reset pll", pll_cfg, exp_pll(9));
    check(div0_word == exp_div0(9) && div1_word == exp_div1(9), "R1", "reset div",
          div0_word, exp_div0(9));
    check(req_ready && !busy && !done && !err, "R1", "reset flags",
          {req_ready, busy, done, err}, 4'b1000);
    for (int l = 0; l < 4; l++) run_xact(l, 1'b0);
    for (int i = 4; i < 16; i++)
      for (int j = 4; j < 16; j++) begin
        run_xact(i, 1'b0);
        run_xact(j, 1'b0);
      end
    run_xact(9, 1'b0);
    stall_div0 = 1'b1;
    timeout_limit = 16'd20;
    run_xact(4, 1'b1);
    stall_div0 = 1'b0;
    timeout_limit = 16'd100;
    repeat (3) @(negedge clk);
    run_xact(4, 1'b0);
    run_xact(15, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule